// File: doc/BRIEF.md
# Configuration request packet builder

This block turns one configuration access into a ready-to-send request packet. A requester presents a command: read or write, target bus, device/function, byte offset, access size (one, two or four bytes) and write data. The block decides whether the access may go out at all. If it may, the block builds a three-doubleword header and, for writes, one data doubleword, and streams them as 64-bit beats with start and end markers over a valid/ready handshake.

The block keeps its own copy of the root bus number, which starts from a parameter. It follows writes that change the primary bus number of the root port. A link-up input gates all accesses beyond the root bus. A rejected command sends nothing. Instead it raises a one-cycle pulse, a flag that tells a hidden-register hit apart from a missing device, and the read value a requester should return.

Top module: `cfg_req_builder`

## Requirements
- R1: Header doubleword 0 carries the type code in bits 31:24 and the length value 1 in its low bits. The code is 0x04 (read) or 0x44 (write) when the target bus equals the stored root bus, and 0x05 (read) or 0x45 (write) for any other bus.
- R2: Header doubleword 1 is {root bus, 8'h00, tag, 4'b0000, byte enables}. The tag is 0x1D for reads and 0x10 for writes.
- R3: Header doubleword 2 is {bus, devfn, offset zero-extended to 16 bits with bits 1:0 cleared}.
- R4: cmd_size encodes 0 as one byte, 1 as two bytes, and 2 or 3 as four bytes. The byte enables are 4'b0001 or 4'b0011 shifted left by offset[1:0] and truncated to 4 bits, or 4'hF for four bytes. Write data is masked to the access width and shifted left by 8*offset[1:0]; a four-byte access passes the data unchanged.
- R5: A write with offset[2:0]==0 is sent in three beats. The first is {DW1,DW0} with start set. The second is {32'h0,DW2} with no marker. The third is {32'h0,data} with end set.
- R6: A write with offset[2:0]!=0 is sent in two beats: {DW1,DW0} with start set, then {data,DW2} with end set.
- R7: A read is sent in two beats: {DW1,DW0} with start set, then {32'h0,DW2} with end set, whatever the offset.
- R8: On the root bus, a device number (devfn[7:3]) other than 0 is rejected. On any other bus, every access is rejected while link_up is low. A rejected command produces no beat and leaves the root bus unchanged.
- R9: An access to the root bus with devfn 0 and offset exactly 0x10 is rejected with rej_bad_reg set. Every other rejection clears rej_bad_reg.
- R10: A write to the root bus whose offset with bits 1:0 cleared equals 0x18 loads the low byte of its lane-shifted data into the stored root bus. The new value appears on root_bus in the cycle after the last beat is accepted.
- R11: A rejection raises rej_pulse for exactly the one cycle after the command is accepted. In that cycle rej_rdata is 0xFFFFFFFF for a read and 0 for a write.
- R12: cmd_ready is low from the accepting edge until the last beat has been accepted. Beat data and markers hold still while tx_valid is high and tx_ready is low.
- R13: After reset, cmd_ready is 1, tx_valid is 0, rej_pulse is 0 and root_bus equals the reset parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_ready | output | 1 | Block is idle and takes a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_bus | input | 8 | Target bus number |
| cmd_devfn | input | 8 | Target device (7:3) and function (2:0) |
| cmd_offset | input | OFS_W | Byte offset in configuration space |
| cmd_size | input | 2 | Access size code |
| cmd_wdata | input | 32 | Write data, right-aligned |
| link_up | input | 1 | Link is trained and usable |
| root_bus | output | 8 | Stored root bus number |
| tx_valid | output | 1 | Beat valid |
| tx_ready | input | 1 | Downstream takes the beat |
| tx_data | output | 64 | Beat payload, low doubleword first |
| tx_sop | output | 1 | First beat of a packet |
| tx_eop | output | 1 | Last beat of a packet |
| rej_pulse | output | 1 | One-cycle rejection indication |
| rej_bad_reg | output | 1 | Rejection was a hidden-register hit |
| rej_rdata | output | 32 | Read value for a rejected access |

## Verification
The properties assume that the downstream side may stall for any number of cycles. They also assume that a command held on the inputs is sampled only when cmd_ready is high. They further assume that link_up and the command fields may change freely between commands. The stimulus drives each command for exactly one accepting cycle and draws tx_ready at random on every cycle. It toggles link_up only between packets. The bus, device and offset draws are biased toward the root bus, device 0, and offsets 0x10 and 0x18, so that the filtering and root-bus tracking paths are hit often.

// File: rtl/cfg_req_pkg.sv
package cfg_req_pkg;

  localparam int BEAT_W = 64;

  typedef struct packed {
    logic [BEAT_W-1:0] data;
    logic              sop;
    logic              eop;
  } beat_t;

  // type code: bit 6 = write, bit 0 = beyond root bus, base 0x04
  function automatic logic [7:0] type_code(input logic wr, input logic far);
    return {1'b0, wr, 4'b0001, 1'b0, far};
  endfunction

  function automatic logic [3:0] byte_en(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      2'd0:    return 4'b0001 << lo;
      2'd1:    return 4'b0011 << lo;
      default: return 4'hF;
    endcase
  endfunction

  function automatic logic [31:0] lane_data(input logic [1:0] sz, input logic [1:0] lo,
                                            input logic [31:0] wd);
    logic [31:0] m;
    case (sz)
      2'd0:    m = 32'h0000_00FF;
      2'd1:    m = 32'h0000_FFFF;
      default: m = 32'hFFFF_FFFF;
    endcase
    if (sz[1]) return wd;
    return (wd & m) << {lo, 3'b000};
  endfunction

endpackage

// File: rtl/cfg_req_filter.sv
module cfg_req_filter #(
  parameter int BUS_W   = 8,
  parameter int DEVFN_W = 8,
  parameter int OFS_W   = 12,
  parameter logic [OFS_W-1:0] BAR_OFS = 'h10
) (
  input  logic [BUS_W-1:0]   bus,
  input  logic [DEVFN_W-1:0] devfn,
  input  logic [OFS_W-1:0]   ofs,
  input  logic [BUS_W-1:0]   root,
  input  logic               link_up,
  output logic               on_root,
  output logic               reject,
  output logic               bad_reg
);
  localparam int FN_W = 3;
  logic dev_nonzero;

  always_comb begin
    on_root     = (bus == root);
    dev_nonzero = |devfn[DEVFN_W-1:FN_W];
    bad_reg     = on_root && (devfn == '0) && (ofs == BAR_OFS);
    reject      = bad_reg || (on_root && dev_nonzero) || (!on_root && !link_up);
  end
endmodule

// File: rtl/cfg_req_hdr.sv
module cfg_req_hdr
  import cfg_req_pkg::*;
#(
  parameter int OFS_W = 12,
  parameter logic [7:0] RD_TAG = 8'h1D,
  parameter logic [7:0] WR_TAG = 8'h10
) (
  input  logic             wr,
  input  logic             on_root,
  input  logic [7:0]       bus,
  input  logic [7:0]       devfn,
  input  logic [OFS_W-1:0] ofs,
  input  logic [1:0]       size,
  input  logic [31:0]      wdata,
  input  logic [7:0]       root,
  output logic [31:0]      dw0,
  output logic [31:0]      dw1,
  output logic [31:0]      dw2,
  output logic [31:0]      dlane
);
  localparam int PAD_W = 16 - OFS_W;
  logic [3:0] be;
  logic [7:0] tag;

  always_comb begin
    be    = byte_en(size, ofs[1:0]);
    tag   = wr ? WR_TAG : RD_TAG;
    dw0   = {type_code(wr, !on_root), 24'd1};
    dw1   = {root, 8'h00, tag, 4'b0000, be};
    dw2   = {bus, devfn, {PAD_W{1'b0}}, ofs[OFS_W-1:2], 2'b00};
    dlane = lane_data(size, ofs[1:0], wdata);
  end
endmodule

// File: rtl/cfg_req_seq.sv
module cfg_req_seq
  import cfg_req_pkg::*;
#(
  parameter int NB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  beat_t         beats_in [NB],
  input  logic [$clog2(NB+1)-1:0] nbeats,
  output logic          busy,
  output logic          tx_valid,
  input  logic          tx_ready,
  output beat_t         tx_beat,
  output logic          last_fire
);
  localparam int IDX_W = $clog2(NB+1);
  beat_t            beats_q [NB];
  logic [IDX_W-1:0] idx_q, nb_q;
  logic             hs;

  assign tx_valid  = busy;
  assign tx_beat   = beats_q[idx_q[$clog2(NB)-1:0]];
  assign hs        = busy && tx_ready;
  assign last_fire = hs && (idx_q == nb_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx_q <= '0;
      nb_q  <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      idx_q <= '0;
      nb_q  <= nbeats;
    end else if (last_fire) begin
      busy  <= 1'b0;
    end else if (hs) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)    beats_q[g] <= '0;
      else if (load) beats_q[g] <= beats_in[g];
    end
  end
endmodule

// File: rtl/cfg_req_builder.sv
module cfg_req_builder
  import cfg_req_pkg::*;
#(
  parameter int OFS_W = 12,
  parameter logic [7:0] ROOT_RST = 8'h00,
  parameter logic [7:0] RD_TAG   = 8'h1D,
  parameter logic [7:0] WR_TAG   = 8'h10,
  parameter logic [OFS_W-1:0] BAR_OFS  = 'h10,
  parameter logic [OFS_W-1:0] PRIM_OFS = 'h18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_write,
  input  logic [7:0]       cmd_bus,
  input  logic [7:0]       cmd_devfn,
  input  logic [OFS_W-1:0] cmd_offset,
  input  logic [1:0]       cmd_size,
  input  logic [31:0]      cmd_wdata,
  input  logic             link_up,
  output logic [7:0]       root_bus,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [63:0]      tx_data,
  output logic             tx_sop,
  output logic             tx_eop,
  output logic             rej_pulse,
  output logic             rej_bad_reg,
  output logic [31:0]      rej_rdata
);
  localparam int NB    = 3;
  localparam int IDX_W = $clog2(NB+1);

  logic        busy, on_root, reject, bad_reg;
  logic        acc_fire, last_fire, qw_aligned, prim_hit;
  logic [31:0] dw0, dw1, dw2, dlane;
  logic [7:0]  root_q, upd_val_q;
  logic        upd_pend_q;
  beat_t       beats [NB];
  beat_t       tx_beat;
  logic [IDX_W-1:0] nbeats;

  assign cmd_ready = !busy;
  assign acc_fire  = cmd_valid && cmd_ready;
  assign root_bus  = root_q;

  cfg_req_filter #(.BUS_W(8), .DEVFN_W(8), .OFS_W(OFS_W), .BAR_OFS(BAR_OFS)) u_filter (
    .bus(cmd_bus), .devfn(cmd_devfn), .ofs(cmd_offset), .root(root_q),
    .link_up(link_up), .on_root(on_root), .reject(reject), .bad_reg(bad_reg)
  );

  cfg_req_hdr #(.OFS_W(OFS_W), .RD_TAG(RD_TAG), .WR_TAG(WR_TAG)) u_hdr (
    .wr(cmd_write), .on_root(on_root), .bus(cmd_bus), .devfn(cmd_devfn),
    .ofs(cmd_offset), .size(cmd_size), .wdata(cmd_wdata), .root(root_q),
    .dw0(dw0), .dw1(dw1), .dw2(dw2), .dlane(dlane)
  );

  always_comb begin
    qw_aligned = cmd_write && (cmd_offset[2:0] == 3'b000);
    prim_hit   = cmd_write && on_root &&
                 ({cmd_offset[OFS_W-1:2], 2'b00} == PRIM_OFS);
    beats[0] = '{data: {dw1, dw0}, sop: 1'b1, eop: 1'b0};
    if (qw_aligned) begin
      beats[1] = '{data: {32'h0, dw2},   sop: 1'b0, eop: 1'b0};
      beats[2] = '{data: {32'h0, dlane}, sop: 1'b0, eop: 1'b1};
      nbeats   = IDX_W'(3);
    end else begin
      beats[1] = '{data: {cmd_write ? dlane : 32'h0, dw2}, sop: 1'b0, eop: 1'b1};
      beats[2] = '0;
      nbeats   = IDX_W'(2);
    end
  end

  cfg_req_seq #(.NB(NB)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(acc_fire && !reject), .beats_in(beats),
    .nbeats(nbeats), .busy(busy), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_beat(tx_beat), .last_fire(last_fire)
  );

  assign tx_data = tx_beat.data;
  assign tx_sop  = tx_beat.sop;
  assign tx_eop  = tx_beat.eop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      root_q      <= ROOT_RST;
      upd_pend_q  <= 1'b0;
      upd_val_q   <= '0;
      rej_pulse   <= 1'b0;
      rej_bad_reg <= 1'b0;
      rej_rdata   <= '0;
    end else begin
      rej_pulse   <= acc_fire && reject;
      rej_bad_reg <= acc_fire && reject && bad_reg;
      rej_rdata   <= (acc_fire && reject && !cmd_write) ? 32'hFFFF_FFFF : 32'h0;
      if (acc_fire && !reject) begin
        upd_pend_q <= prim_hit;
        upd_val_q  <= dlane[7:0];
      end else if (last_fire) begin
        upd_pend_q <= 1'b0;
        if (upd_pend_q) root_q <= upd_val_q;
      end
    end
  end
endmodule

// File: rtl/cfg_req_checker.sv
module cfg_req_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [63:0] tx_data,
  input logic        tx_sop,
  input logic        tx_eop,
  input logic        rej_pulse,
  input logic [7:0]  root_bus,
  input logic        acc_fire,
  input logic        last_fire
);
  a_r12_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop));

  a_r12_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !cmd_ready);

  a_r12_resume: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> cmd_ready && !tx_valid);

  a_r5_first_is_sop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> tx_sop);

  a_r6_markers_apart: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !(tx_sop && tx_eop));

  a_r8_no_beat_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
    rej_pulse |-> !tx_valid);

  a_r11_pulse_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    rej_pulse |-> $past(acc_fire));

  a_r10_root_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(root_bus) |-> $past(last_fire));
endmodule

bind cfg_req_builder cfg_req_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop),
  .rej_pulse(rej_pulse), .root_bus(root_bus), .acc_fire(acc_fire),
  .last_fire(last_fire)
);

// File: tb/test_cfg_req_builder.sv
`timescale 1ns/1ps
module test_cfg_req_builder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [7:0]  cmd_bus = '0, cmd_devfn = '0;
  logic [11:0] cmd_offset = '0;
  logic [1:0]  cmd_size = '0;
  logic [31:0] cmd_wdata = '0;
  logic        link_up = 1'b1, tx_ready = 1'b0;
  logic        cmd_ready, tx_valid, tx_sop, tx_eop, rej_pulse, rej_bad_reg;
  logic [7:0]  root_bus;
  logic [63:0] tx_data;
  logic [31:0] rej_rdata;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0] tb_root = 8'h00;

  always #2.5 clk = ~clk;

  cfg_req_builder i_cfg_req_builder (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_bus(cmd_bus), .cmd_devfn(cmd_devfn),
    .cmd_offset(cmd_offset), .cmd_size(cmd_size), .cmd_wdata(cmd_wdata),
    .link_up(link_up), .root_bus(root_bus), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop), .rej_pulse(rej_pulse),
    .rej_bad_reg(rej_bad_reg), .rej_rdata(rej_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] m_be(input logic [1:0] sz, input logic [11:0] of);
    int n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    logic [3:0] r = '0;
    if (n == 4) return 4'hF;
    for (int b = 0; b < 4; b++) r[b] = (b >= of[1:0]) && (b < of[1:0] + n);
    return r;
  endfunction

  function automatic logic [31:0] m_data(input logic [1:0] sz, input logic [11:0] of, input logic [31:0] w);
    logic [63:0] p;
    if (sz >= 2'd2) return w;
    p = (sz == 2'd0) ? {56'd0, w[7:0]} : {48'd0, w[15:0]};
    p = p * (64'd1 << (8 * of[1:0]));
    return p[31:0];
  endfunction

  task automatic run_req(input bit wr, input logic [7:0] b, input logic [7:0] df,
                         input logic [11:0] of, input logic [1:0] sz, input logic [31:0] wd);
    bit near = (b == tb_root);
    bit bad  = near && df == 8'h00 && of == 12'h010;
    bit rej  = bad || (near && df[7:3] != 0) || (!near && !link_up);
    logic [31:0] d0, d1, d2, dd;
    logic [65:0] ex [3];
    int nexp, n, guard;
    bit done;
    string tag;
    d0 = {(near ? (wr ? 8'h44 : 8'h04) : (wr ? 8'h45 : 8'h05)), 24'h000001};
    d1 = {tb_root, 8'h00, (wr ? 8'h10 : 8'h1D), 4'h0, m_be(sz, of)};
    d2 = {b, df, 4'h0, of[11:2], 2'b00};
    dd = m_data(sz, of, wd);
    ex[0] = {d1, d0, 1'b1, 1'b0};
    if (wr && of[2:0] == 0) begin
      ex[1] = {32'h0, d2, 2'b00}; ex[2] = {32'h0, dd, 2'b01}; nexp = 3; tag = "R5";
    end else if (wr) begin
      ex[1] = {dd, d2, 2'b01}; ex[2] = '0; nexp = 2; tag = "R6";
    end else begin
      ex[1] = {32'h0, d2, 2'b01}; ex[2] = '0; nexp = 2; tag = "R7";
    end
    @(negedge clk);
    chk(cmd_ready === 1'b1, "R12 idle before command", {65'd0, cmd_ready}, 66'd1);
    cmd_valid = 1'b1; cmd_write = wr; cmd_bus = b; cmd_devfn = df;
    cmd_offset = of; cmd_size = sz; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (rej) begin
      chk(rej_pulse === 1'b1 && tx_valid === 1'b0, "R8 reject pulse, no beat",
          {64'd0, rej_pulse, tx_valid}, {64'd0, 2'b10});
      chk(rej_bad_reg === bad, "R9 bad register flag", {65'd0, rej_bad_reg}, {65'd0, bad});
      chk(rej_rdata === (wr ? 32'h0 : 32'hFFFF_FFFF), "R11 rejected read value",
          {34'd0, rej_rdata}, {34'd0, (wr ? 32'h0 : 32'hFFFF_FFFF)});
      @(negedge clk);
      chk(rej_pulse === 1'b0 && tx_valid === 1'b0 && root_bus === tb_root,
          "R11 single pulse, R8 root unchanged", {57'd0, rej_pulse, tx_valid, root_bus},
          {57'd0, 2'b00, tb_root});
    end else begin
      chk(rej_pulse === 1'b0, "R8 accepted command not rejected", {65'd0, rej_pulse}, 66'd0);
      n = 0; done = 0; guard = 0;
      while (!done && guard < 60) begin
        tx_ready = ($urandom % 4) != 0;
        if (tx_valid && tx_ready) begin
          if (n < nexp)
            chk({tx_data, tx_sop, tx_eop} === ex[n],
                (n == 0) ? "R1 R2 R4 first beat" : {tag, " R3 R4 beat"},
                {tx_data, tx_sop, tx_eop}, ex[n]);
          else
            chk(1'b0, {tag, " extra beat"}, {tx_data, tx_sop, tx_eop}, 66'd0);
          n++;
          if (tx_eop) done = 1;
        end else if (tx_valid) begin
          if (cmd_ready !== 1'b0) chk(1'b0, "R12 ready while busy", {65'd0, cmd_ready}, 66'd0);
        end
        @(negedge clk);
        guard++;
      end
      tx_ready = 1'b0;
      chk(n == nexp, {tag, " beat count"}, 66'(n), 66'(nexp));
      chk(cmd_ready === 1'b1 && tx_valid === 1'b0, "R12 idle after last beat",
          {64'd0, cmd_ready, tx_valid}, {64'd0, 2'b10});
      if (wr && near && {of[11:2], 2'b00} == 12'h018) tb_root = dd[7:0];
      chk(root_bus === tb_root, "R10 root bus tracking", {58'd0, root_bus}, {58'd0, tb_root});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmd_ready === 1'b1 && tx_valid === 1'b0 && rej_pulse === 1'b0 && root_bus === 8'h00,
        "R13 reset state", {55'd0, cmd_ready, tx_valid, rej_pulse, root_bus}, {55'd0, 3'b100, 8'h00});
    rst_n = 1'b1;
    // directed corners
    run_req(1, 8'h01, 8'h08, 12'h020, 2'd2, 32'hCAFE_F00D);   // aligned write, type 1
    run_req(1, 8'h00, 8'h00, 12'h044, 2'd2, 32'h1234_5678);   // unaligned write, type 0
    run_req(0, 8'h00, 8'h00, 12'h000, 2'd2, 32'h0);           // read aligned offset
    run_req(1, 8'h02, 8'h10, 12'h023, 2'd0, 32'hAABB_CC5A);   // byte at lane 3
    run_req(1, 8'h02, 8'h10, 12'h026, 2'd1, 32'hAABB_9876);   // half at lane 2
    run_req(1, 8'h02, 8'h10, 12'h007, 2'd1, 32'h0000_BEEF);   // half at lane 3, truncated enables
    run_req(0, 8'h00, 8'h08, 12'h000, 2'd2, 32'h0);           // device 1 on root: reject
    run_req(0, 8'h00, 8'h00, 12'h010, 2'd2, 32'h0);           // hidden register
    run_req(1, 8'h00, 8'h00, 12'h010, 2'd2, 32'h1);           // hidden register write
    run_req(0, 8'h00, 8'h01, 12'h010, 2'd2, 32'h0);           // function 1 is allowed
    link_up = 1'b0;
    run_req(0, 8'h05, 8'h00, 12'h000, 2'd2, 32'h0);           // link down, far bus
    run_req(0, 8'h00, 8'h00, 12'h004, 2'd2, 32'h0);           // link down, root bus fine
    link_up = 1'b1;
    run_req(1, 8'h00, 8'h00, 12'h018, 2'd2, 32'h0003_0201);   // root bus becomes 0x01
    run_req(0, 8'h01, 8'h00, 12'h000, 2'd2, 32'h0);           // now type 0
    run_req(0, 8'h00, 8'h00, 12'h000, 2'd2, 32'h0);           // now type 1
    run_req(1, 8'h01, 8'h00, 12'h019, 2'd0, 32'h0000_0007);   // byte write, root byte from lane 0
    // constrained random
    for (int i = 0; i < 250; i++) begin
      logic [7:0] b, df;
      logic [11:0] of;
      int pick = $urandom % 4;
      b  = (pick == 0) ? tb_root + 8'd1 : (pick == 1) ? 8'($urandom) : tb_root;
      df = ($urandom % 2) ? 8'h00 : 8'($urandom);
      pick = $urandom % 6;
      of = (pick == 0) ? 12'h010 : (pick == 1) ? 12'(12'h018 + ($urandom % 4)) : 12'($urandom);
      if ($urandom % 8 == 0) link_up = ~link_up;
      run_req(1'($urandom), b, df, of, 2'($urandom), $urandom);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule